// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It holds two direction predictors and a selector. The first predictor is global. It indexes a table of 2-bit counters with the outcomes of the most recent branches, whichever branches they were. The second predictor is local and works in two levels. The branch address picks a per-branch history of recent outcomes, and that history pattern then picks a 3-bit counter. A table of 2-bit selector counters, indexed by branch address, decides which of the two predictions is returned.

The fetch side presents an instruction address on the predict port. It receives a direction and a flag that shows which predictor supplied it, in the same cycle, through combinational logic only. When a branch resolves, the back end presents the address and the real outcome on the update port. At the next clock edge the block trains both predictors and trains the selector when the two predictors disagreed. It then shifts the outcome into the global history and into that branch's local history. History is updated only at resolve time, so no recovery path is needed.

Top module: `tournament_predictor`

## Requirements
- R1: After reset, every 2-bit counter in the global and selector tables holds 1 and every 3-bit local counter holds 3. Every local history and the global history hold 0. With no update applied, `pred_taken_o` and `pred_use_local_o` are therefore 0 for any address.
- R2: The selector entry is chosen by address bits [13:2]. An entry value of 2 or 3 selects the local prediction and drives `pred_use_local_o`=1. Values 0 and 1 select the global prediction and drive `pred_use_local_o`=0. Addresses that differ only outside bits [13:2] share one selector entry.
- R3: The global prediction is taken when the 2-bit counter indexed by the 12-bit global history holds 2 or more.
- R4: The local history entry is chosen by address bits [11:2]. Its 10-bit value indexes the 3-bit counter table, and the local prediction is taken when that counter holds 4 or more.
- R5: On an update, the global counter and the local counter that the update address would have used both step by one. They step up on taken and down on not-taken, and they saturate at 0 and at their maximum without wrapping.
- R6: The selector entry of the update address changes only when the global and local predictions for that update disagree. It then steps one toward local if local was correct, or one toward global if global was correct, and it saturates at 0 and 3.
- R7: An update shifts the outcome (1 = taken) into bit 0 of the global history and into bit 0 of that branch's local history. Older bits move up one place and the oldest bit is dropped.
- R8: The predict port reflects state as of the last clock edge. An update becomes visible at the next edge, so a prediction in the same cycle as an update of the same branch still sees the old state.
- R9: While `upd_valid_i` is 0, the values on `upd_pc_i` and `upd_taken_i` change no table and no history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pred_pc_i | input | 32 | Address of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_use_local_o | output | 1 | 1 when the local predictor supplied the prediction |
| upd_valid_i | input | 1 | Resolved branch present this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome of the resolved branch |

## Verification
Both predict outputs are combinational, so each result is due in the cycle its address is applied. The bench drives inputs on the falling edge and compares the outputs with the model 1 ns later, before the next rising edge. An update takes effect at the following rising edge. The model applies it right after that edge, so the comparison on the next falling edge is the first that expects the new state, and a same-cycle comparison still expects the old state.

// File: rtl/tp_pkg.sv
package tp_pkg;
  localparam int unsigned ALIGN_LSB = 2;
  localparam int unsigned MAX_CTR_W = 8;

  function automatic logic [MAX_CTR_W-1:0] sat_move(input logic [MAX_CTR_W-1:0] cur,
                                                    input logic [MAX_CTR_W-1:0] top,
                                                    input logic up);
    if (up) return (cur == top) ? cur : cur + 1'b1;
    return (cur == '0) ? cur : cur - 1'b1;
  endfunction
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int unsigned IDX_W   = 12,
  parameter int unsigned CTR_W   = 2,
  parameter int unsigned RST_VAL = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [CTR_W-1:0] rd_ctr_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_up_i,
  output logic [CTR_W-1:0] upd_ctr_o
);
  import tp_pkg::*;
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [MAX_CTR_W-1:0] TOP = MAX_CTR_W'((1 << CTR_W) - 1);

  logic [CTR_W-1:0]     mem [DEPTH];
  logic [MAX_CTR_W-1:0] nxt_wide;

  assign rd_ctr_o  = mem[rd_idx_i];
  assign upd_ctr_o = mem[upd_idx_i];

  always_comb nxt_wide = sat_move(MAX_CTR_W'(upd_ctr_o), TOP, upd_up_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_W'(RST_VAL);
    end else if (upd_en_i) begin
      mem[upd_idx_i] <= nxt_wide[CTR_W-1:0];
    end
  end

  AST_NO_WRAP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && upd_up_i |=> mem[$past(upd_idx_i)] >= $past(upd_ctr_o)); // R5
  AST_NO_WRAP_DN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i && !upd_up_i |=> mem[$past(upd_idx_i)] <= $past(upd_ctr_o)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> mem[$past(upd_idx_i)] == $past(upd_ctr_o)); // R9
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic              upd_taken_i,
  output logic [HIST_W-1:0] upd_hist_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  assign rd_hist_o  = mem[rd_idx_i];
  assign upd_hist_o = mem[upd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (upd_en_i) begin
      mem[upd_idx_i] <= {upd_hist_o[HIST_W-2:0], upd_taken_i};
    end
  end

  AST_LHIST_NEWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_en_i |=> mem[$past(upd_idx_i)][0] == $past(upd_taken_i)); // R7
  AST_LHIST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_en_i |=> mem[$past(upd_idx_i)] == $past(upd_hist_o)); // R9
endmodule

// File: rtl/tournament_predictor.sv
module tournament_predictor #(
  parameter int unsigned PC_W         = 32,
  parameter int unsigned GHIST_W      = 12,
  parameter int unsigned SEL_IDX_W    = 12,
  parameter int unsigned LHT_IDX_W    = 10,
  parameter int unsigned LHIST_W      = 10,
  parameter int unsigned GCTR_W       = 2,
  parameter int unsigned LCTR_W       = 3,
  parameter int unsigned SEL_W        = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_use_local_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  import tp_pkg::*;
  // weakly-not-taken / weakly-global: one below the midpoint
  localparam int unsigned G_WEAK  = (1 << (GCTR_W - 1)) - 1;
  localparam int unsigned L_WEAK  = (1 << (LCTR_W - 1)) - 1;
  localparam int unsigned S_WEAK  = (1 << (SEL_W - 1)) - 1;

  logic [GHIST_W-1:0]   ghist_q;
  logic [SEL_IDX_W-1:0] p_sel_idx, u_sel_idx;
  logic [LHT_IDX_W-1:0] p_lht_idx, u_lht_idx;
  logic [LHIST_W-1:0]   p_lhist, u_lhist;
  logic [GCTR_W-1:0]    p_gctr, u_gctr;
  logic [LCTR_W-1:0]    p_lctr, u_lctr;
  logic [SEL_W-1:0]     p_sel, u_sel;
  logic                 u_gpred, u_lpred, u_disagree;

  assign p_sel_idx = SEL_IDX_W'(pred_pc_i >> ALIGN_LSB);
  assign u_sel_idx = SEL_IDX_W'(upd_pc_i >> ALIGN_LSB);
  assign p_lht_idx = LHT_IDX_W'(pred_pc_i >> ALIGN_LSB);
  assign u_lht_idx = LHT_IDX_W'(upd_pc_i >> ALIGN_LSB);

  // counter MSB set = taken / prefer local
  assign u_gpred    = u_gctr[GCTR_W-1];
  assign u_lpred    = u_lctr[LCTR_W-1];
  assign u_disagree = u_gpred ^ u_lpred;

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W), .RST_VAL(G_WEAK)) u_gtab (
    .clk_i, .rst_ni,
    .rd_idx_i (ghist_q),
    .rd_ctr_o (p_gctr),
    .upd_en_i (upd_valid_i),
    .upd_idx_i(ghist_q),
    .upd_up_i (upd_taken_i),
    .upd_ctr_o(u_gctr)
  );

  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i   (p_lht_idx),
    .rd_hist_o  (p_lhist),
    .upd_en_i   (upd_valid_i),
    .upd_idx_i  (u_lht_idx),
    .upd_taken_i(upd_taken_i),
    .upd_hist_o (u_lhist)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W), .RST_VAL(L_WEAK)) u_ltab (
    .clk_i, .rst_ni,
    .rd_idx_i (p_lhist),
    .rd_ctr_o (p_lctr),
    .upd_en_i (upd_valid_i),
    .upd_idx_i(u_lhist),
    .upd_up_i (upd_taken_i),
    .upd_ctr_o(u_lctr)
  );

  tp_ctr_table #(.IDX_W(SEL_IDX_W), .CTR_W(SEL_W), .RST_VAL(S_WEAK)) u_sel_tab (
    .clk_i, .rst_ni,
    .rd_idx_i (p_sel_idx),
    .rd_ctr_o (p_sel),
    .upd_en_i (upd_valid_i && u_disagree),
    .upd_idx_i(u_sel_idx),
    .upd_up_i (u_lpred == upd_taken_i),
    .upd_ctr_o(u_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghist_q <= '0;
    else if (upd_valid_i) ghist_q <= {ghist_q[GHIST_W-2:0], upd_taken_i};
  end

  assign pred_use_local_o = p_sel[SEL_W-1];
  assign pred_taken_o     = pred_use_local_o ? p_lctr[LCTR_W-1] : p_gctr[GCTR_W-1];

  AST_GHIST_NEWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghist_q[0] == $past(upd_taken_i)); // R7
  AST_GHIST_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghist_q)); // R9
  AST_SEL_AGREE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i && !u_disagree && (u_sel_idx == p_sel_idx)
      |=> (p_sel == $past(u_sel)) || (p_sel_idx != $past(p_sel_idx))); // R6
endmodule

// File: tb/tournament_predictor_test.sv
`timescale 1ns/1ps
module tournament_predictor_test;
  localparam int GN = 4096;
  localparam int LN = 1024;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        pred_taken_o, pred_use_local_o;
  logic        upd_valid_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int ghist;
  int gctr [GN];
  int sel  [GN];
  int lhist[LN];
  int lctr [LN];
  int unsigned rng = 32'h1234_5678;

  always #4 clk_i = ~clk_i;

  tournament_predictor uut (
    .clk_i, .rst_ni, .pred_pc_i, .pred_taken_o, .pred_use_local_o,
    .upd_valid_i, .upd_pc_i, .upd_taken_i
  );

  function automatic int unsigned rnd();
    rng ^= rng << 13;
    rng ^= rng >> 17;
    rng ^= rng << 5;
    return rng;
  endfunction

  function automatic int bump(int v, int top, bit up);
    if (up) return (v < top) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  task automatic model_reset();
    ghist = 0;
    for (int i = 0; i < GN; i++) begin gctr[i] = 1; sel[i] = 1; end
    for (int i = 0; i < LN; i++) begin lhist[i] = 0; lctr[i] = 3; end
  endtask

  task automatic model_update(int unsigned pc, bit t);
    int li, ci, h;
    bit gp, lp;
    li = (pc >> 2) & (LN - 1);
    ci = (pc >> 2) & (GN - 1);
    h  = lhist[li];
    gp = gctr[ghist] >= 2;
    lp = lctr[h] >= 4;
    gctr[ghist] = bump(gctr[ghist], 3, t);
    lctr[h]     = bump(lctr[h], 7, t);
    if (gp != lp) sel[ci] = bump(sel[ci], 3, lp == t);
    lhist[li] = ((h << 1) | int'(t)) & (LN - 1);
    ghist     = ((ghist << 1) | int'(t)) & (GN - 1);
  endtask

  task automatic chk(int got, int exp, string tag, string what);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  // drive at falling edge, compare 1 ns later, model update after rising edge
  task automatic step(int unsigned ppc, bit uv, int unsigned upc, bit ut, string tag);
    bit exp_local, exp_taken;
    @(negedge clk_i);
    pred_pc_i   = ppc;
    upd_valid_i = uv;
    upd_pc_i    = upc;
    upd_taken_i = ut;
    #1;
    exp_local = sel[(ppc >> 2) & (GN - 1)] >= 2;
    exp_taken = exp_local ? (lctr[lhist[(ppc >> 2) & (LN - 1)]] >= 4) : (gctr[ghist] >= 2);
    chk(int'(pred_use_local_o), int'(exp_local), tag, "use_local");
    chk(int'(pred_taken_o), int'(exp_taken), tag, "taken");
    @(posedge clk_i);
    if (uv) model_update(upc, ut);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1: reset state across several addresses, no updates
    for (int i = 0; i < 6; i++) step(32'h40 * i + 32'hF000_0000 * i, 0, 0, 0, "R1");

    // R3: always-taken stream trains the global counters
    for (int i = 0; i < 20; i++) step(32'h200, 1, 32'h200, 1, "R3");

    // R4: loop pattern T,T,T,N learned by the local predictor
    for (int i = 0; i < 240; i++) step(32'h100, 1, 32'h100, (i % 4) != 3, "R4");

    // R5: saturation at both ends on a single branch
    for (int i = 0; i < 14; i++) step(32'h40, 1, 32'h40, 0, "R5");
    for (int i = 0; i < 14; i++) step(32'h40, 1, 32'h40, 1, "R5");

    // R6: per-branch periodic patterns that make the components disagree
    for (int i = 0; i < 600; i++) begin
      int unsigned pc;
      pc = 32'h1000 + 32'h4 * (i % 5);
      step(pc, 1, pc, ((i / 5) % 3) == 0, "R6");
    end

    // R7: two interleaved branches with opposite phases
    for (int i = 0; i < 200; i++)
      step(32'h800 + 32'h4 * (i % 2), 1, 32'h800 + 32'h4 * (i % 2), (i % 2) ^ ((i / 2) % 2), "R7");

    // R8: predict and update the same branch in the same cycle
    for (int i = 0; i < 150; i++) begin
      int unsigned pc;
      pc = 32'h3000 + 32'h4 * (rnd() % 3);
      step(pc, 1, pc, rnd() % 4 != 0, "R8");
    end

    // R9: update port busy but not valid; state must not move
    for (int i = 0; i < 60; i++) begin
      int unsigned pc;
      pc = 32'h1000 + 32'h4 * (i % 5);
      step(pc, 0, pc, i % 2, "R9");
    end

    // R2: random mix including aliases differing above bit 13
    for (int i = 0; i < 1500; i++) begin
      int unsigned pc, pp;
      pc = (32'h4 * (rnd() % 16)) | ((rnd() % 4) << 14);
      pp = (32'h4 * (rnd() % 16)) | ((rnd() % 4) << 20);
      step(pp, rnd() % 8 != 0, pc, ((pc >> 2) % 3 == 0) ? (rnd() % 2) : ((pc >> 2) % 2), "R2");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule